// File: doc/BRIEF.md
# Sync Timing and Polarity Meter

This block measures the incoming horizontal and vertical sync signals of a multi-sync display controller and regenerates both syncs with a polarity chosen by software. A single counter serves both measurements in turn. In vertical mode it counts strobes of a 31.25 kHz time base between two rising edges of the vertical sync. In horizontal mode it counts rising edges of the horizontal sync during one period of a slower window strobe, which runs at 122.07 Hz. One count in this mode therefore stands for 122.07 Hz of line rate.

When a measurement ends, the result stays frozen and a ready flag is raised. The flag can drive an interrupt. Software reads the count register to collect the result. That read also hands the counter over to the other measurement. The counter can wrap around past its top value. The first wrap is recorded in one overflow flag. The measurement then keeps counting, and a second wrap ends it with a second flag. This extends the range of vertical periods that can be measured.

The polarity of each input is found by comparing its high time with its low time over one period. The regenerated outputs are inverted whenever the detected polarity differs from the polarity that software requests.

Top module: `sync_meter`

## Requirements
- R1: After reset the count reads 0, the interrupt is low and the mode is vertical. The whole status word reads 0. Status bit layout: 0 ready, 1 first overflow, 2 second overflow, 3 vertical polarity, 4 horizontal polarity, 5 mode (1 = horizontal), 6 vertical output polarity, 7 horizontal output polarity, 8 interrupt enable. Status is read at `bus_addr`=1 and the count at `bus_addr`=0.
- R2: In vertical mode, the count equals the number of `tick_vclk` strobes from one synchronised vertical rising edge up to, but not including, the next. Ready is then set and the count holds until it is collected.
- R3: `sync_irq` is high exactly while ready is set and the interrupt enable (control bit 2) is 1.
- R4: A read at `bus_addr`=0 clears ready, both overflow flags and the count, toggles the mode and starts a new measurement. A read at `bus_addr`=1 changes nothing.
- R5: In horizontal mode, the count equals the number of synchronised horizontal rising edges from one `win_strobe` up to, but not including, the next. Ready is then set.
- R6: A polarity status bit is 1 when the input's high time over its last full period was shorter than its low time, and 0 otherwise.
- R7: Control bit 1 selects the horizontal output polarity and control bit 0 selects the vertical one, with 1 meaning positive. The output has its pulse at that polarity whatever the input polarity is.
- R8: The first wrap of the counter past its maximum sets the first overflow flag, and counting continues. If the measurement then ends normally, the count holds the residue after the wrap.
- R9: The second wrap sets the second overflow flag, clears the first, sets ready and stops counting with the count at 0.
- R10: The two overflow flags are never set together.
- R11: The control bits are written only by a write at `bus_addr`=1. A write at `bus_addr`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_vclk | input | 1 | One-cycle strobe of the 31.25 kHz vertical time base |
| win_strobe | input | 1 | One-cycle strobe that bounds the horizontal counting window |
| hsync_in | input | 1 | Horizontal sync input, asynchronous |
| vsync_in | input | 1 | Vertical sync input, asynchronous |
| bus_addr | input | 1 | Register select: 0 count, 1 status/control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 3 | Control write data (bit 0 vertical out polarity, bit 1 horizontal out polarity, bit 2 interrupt enable) |
| bus_rdata | output | RD_W (10) | Read data for the selected register |
| sync_irq | output | 1 | Measurement-ready interrupt |
| hsync_out | output | 1 | Regenerated horizontal sync |
| vsync_out | output | 1 | Regenerated vertical sync |

## Verification
The assertions assume three things about the inputs. The time-base and window strobes are single-cycle pulses. Each sync pulse and gap lasts longer than the synchroniser, so every rising edge is seen once. Every bus read is a one-cycle strobe, so a collection performs exactly one handoff. The stimulus respects this: both strobes come from cycle dividers, the syncs have pulses of at least two cycles and periods that are exact multiples of the time base or window, and each register access lasts exactly one cycle. The sync generators are switched on only after reset, so that a level that is already high is not mistaken for an edge.

// File: rtl/sm_pkg.sv
package sm_pkg;
   // control register bit positions
   localparam int CTRL_W  = 3;
   localparam int CTL_VOP = 0;
   localparam int CTL_HOP = 1;
   localparam int CTL_IEN = 2;
   // status word bit positions
   localparam int ST_RDY  = 0;
   localparam int ST_OVF1 = 1;
   localparam int ST_OVF2 = 2;
   localparam int ST_VPOL = 3;
   localparam int ST_HPOL = 4;
   localparam int ST_HV   = 5;
   localparam int ST_VOP  = 6;
   localparam int ST_HOP  = 7;
   localparam int ST_IEN  = 8;
   localparam int STAT_W  = 9;
   // register addresses
   localparam logic ADDR_CNT = 1'b0;
   localparam logic ADDR_CTL = 1'b1;
   // sync channel indices
   localparam int CH_H = 0;
   localparam int CH_V = 1;
   localparam int N_CH = 2;

   typedef enum logic [1:0] {
      MS_ARM,
      MS_RUN,
      MS_DONE
   } meas_state_e;
endpackage

// File: rtl/sm_sync_edge.sv
module sm_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sm_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         last_q  <= chain_q[STAGES-1];
      end
   end

   always_comb begin
      level = chain_q[STAGES-1];
      rise  = chain_q[STAGES-1] & ~last_q;
   end
endmodule

// File: rtl/sm_pol_detect.sv
module sm_pol_detect #(
   parameter int POL_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic rise,
   output logic pol_pos
);
   logic [POL_W-1:0] hi_q;
   logic [POL_W-1:0] lo_q;
   logic             seen_q;

   generate
      if (POL_W < 2) begin : g_bad_polw
         $error("sm_pol_detect: POL_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         seen_q  <= 1'b0;
         pol_pos <= 1'b0;
      end else if (rise) begin
         // close one full period, then start the next with this high cycle
         if (seen_q) pol_pos <= (hi_q < lo_q);
         seen_q <= 1'b1;
         hi_q   <= {{(POL_W-1){1'b0}}, 1'b1};
         lo_q   <= '0;
      end else if (level) begin
         if (hi_q != {POL_W{1'b1}}) hi_q <= hi_q + 1'b1;
      end else begin
         if (lo_q != {POL_W{1'b1}}) lo_q <= lo_q + 1'b1;
      end
   end
endmodule

// File: rtl/sm_freq_count.sv
module sm_freq_count
   import sm_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             win,
   input  logic             h_rise,
   input  logic             v_rise,
   input  logic             handoff,
   output logic [CNT_W-1:0] cnt,
   output logic             rdy,
   output logic             ovf1,
   output logic             ovf2,
   output logic             hv
);
   meas_state_e st_q;
   logic        bound_ev;
   logic        inc_ev;

   // hv = 0: vertical period in time-base ticks; hv = 1: line edges per window
   always_comb begin
      bound_ev = hv ? win    : v_rise;
      inc_ev   = hv ? h_rise : tick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= MS_ARM;
         cnt  <= '0;
         rdy  <= 1'b0;
         ovf1 <= 1'b0;
         ovf2 <= 1'b0;
         hv   <= 1'b0;
      end else if (handoff) begin
         st_q <= MS_ARM;
         cnt  <= '0;
         rdy  <= 1'b0;
         ovf1 <= 1'b0;
         ovf2 <= 1'b0;
         hv   <= ~hv;
      end else begin
         case (st_q)
            MS_ARM: begin
               if (bound_ev) begin
                  st_q <= MS_RUN;
                  cnt  <= {{(CNT_W-1){1'b0}}, inc_ev};
               end
            end
            MS_RUN: begin
               if (bound_ev) begin
                  st_q <= MS_DONE;
                  rdy  <= 1'b1;
               end else if (inc_ev) begin
                  cnt <= cnt + 1'b1;
                  if (&cnt) begin
                     if (ovf1) begin
                        ovf1 <= 1'b0;
                        ovf2 <= 1'b1;
                        rdy  <= 1'b1;
                        st_q <= MS_DONE;
                     end else begin
                        ovf1 <= 1'b1;
                     end
                  end
               end
            end
            default: begin
               st_q <= MS_DONE;
            end
         endcase
      end
   end
endmodule

// File: rtl/sync_meter.sv
module sync_meter
   import sm_pkg::*;
#(
   parameter  int CNT_W       = 10,
   parameter  int SYNC_STAGES = 2,
   parameter  int POL_W       = 16,
   localparam int RD_W        = (CNT_W > STAT_W) ? CNT_W : STAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_vclk,
   input  logic              win_strobe,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic              bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [RD_W-1:0]   bus_rdata,
   output logic              sync_irq,
   output logic              hsync_out,
   output logic              vsync_out
);
   generate
      if (CNT_W < 4) begin : g_bad_cntw
         $error("sync_meter: CNT_W must be at least 4");
      end
   endgenerate

   logic [N_CH-1:0]   raw_in;
   logic [N_CH-1:0]   lvl;
   logic [N_CH-1:0]   rise;
   logic [N_CH-1:0]   pol;
   logic [N_CH-1:0]   want_pos;
   logic [N_CH-1:0]   regen;
   logic [CTRL_W-1:0] ctl_q;
   logic [CNT_W-1:0]  cnt;
   logic              rdy;
   logic              ovf1;
   logic              ovf2;
   logic              hv;
   logic              handoff;

   always_comb begin
      raw_in[CH_H]   = hsync_in;
      raw_in[CH_V]   = vsync_in;
      want_pos[CH_H] = ctl_q[CTL_HOP];
      want_pos[CH_V] = ctl_q[CTL_VOP];
      handoff        = bus_rd && (bus_addr == ADDR_CNT);
   end

   // per-channel synchroniser, polarity detector and regenerator
   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
         sm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[ch]),
            .level (lvl[ch]),
            .rise  (rise[ch])
         );
         sm_pol_detect #(.POL_W(POL_W)) u_pol (
            .clk     (clk),
            .rst_n   (rst_n),
            .level   (lvl[ch]),
            .rise    (rise[ch]),
            .pol_pos (pol[ch])
         );
         always_comb regen[ch] = lvl[ch] ^ (pol[ch] ^ want_pos[ch]);
      end
   endgenerate

   sm_freq_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_vclk),
      .win     (win_strobe),
      .h_rise  (rise[CH_H]),
      .v_rise  (rise[CH_V]),
      .handoff (handoff),
      .cnt     (cnt),
      .rdy     (rdy),
      .ovf1    (ovf1),
      .ovf2    (ovf2),
      .hv      (hv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctl_q <= '0;
      else if (bus_wr && bus_addr == ADDR_CTL) ctl_q <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_CNT) begin
         bus_rdata[CNT_W-1:0] = cnt;
      end else begin
         bus_rdata[ST_RDY]  = rdy;
         bus_rdata[ST_OVF1] = ovf1;
         bus_rdata[ST_OVF2] = ovf2;
         bus_rdata[ST_VPOL] = pol[CH_V];
         bus_rdata[ST_HPOL] = pol[CH_H];
         bus_rdata[ST_HV]   = hv;
         bus_rdata[ST_VOP]  = ctl_q[CTL_VOP];
         bus_rdata[ST_HOP]  = ctl_q[CTL_HOP];
         bus_rdata[ST_IEN]  = ctl_q[CTL_IEN];
      end
      sync_irq  = rdy & ctl_q[CTL_IEN];
      hsync_out = regen[CH_H];
      vsync_out = regen[CH_V];
   end
endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rd,
   input logic             bus_addr,
   input logic             irq,
   input logic             rdy,
   input logic             ovf1,
   input logic             ovf2,
   input logic             hv,
   input logic [CNT_W-1:0] cnt,
   input logic             hpol,
   input logic             vpol,
   input logic             h_rise,
   input logic             v_rise
);
   AST_OVF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf1 && ovf2)); // R10
   AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rdy); // R3
   AST_HANDOFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 1'b0) |=> (hv != $past(hv))); // R4
   AST_HANDOFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 1'b0) |=> (!rdy && !ovf1 && !ovf2 && cnt == '0)); // R4
   AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !(bus_rd && bus_addr == 1'b0)) |=> $stable(cnt)); // R2
   AST_SECOND_WRAP_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf2) |-> (rdy && cnt == '0)); // R9
   AST_HPOL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hpol) |-> $past(h_rise)); // R6
   AST_VPOL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vpol) |-> $past(v_rise)); // R6
endmodule

bind sync_meter sm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .bus_rd (bus_rd),
   .bus_addr(bus_addr),
   .irq    (sync_irq),
   .rdy    (rdy),
   .ovf1   (ovf1),
   .ovf2   (ovf2),
   .hv     (hv),
   .cnt    (cnt),
   .hpol   (pol[0]),
   .vpol   (pol[1]),
   .h_rise (rise[0]),
   .v_rise (rise[1])
);

// File: tb/sync_meter_bench.sv
module sync_meter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_vclk = 1'b0;
   logic       win_strobe = 1'b0;
   logic       hsync_in = 1'b0;
   logic       vsync_in = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_wdata = 3'b000;
   logic [9:0] bus_rdata;
   logic       sync_irq;
   logic       hsync_out;
   logic       vsync_out;

   int n_chk = 0;
   int n_fail = 0;

   // stimulus knobs
   int tick_per = 4;
   int win_per  = 2560;
   int hs_per = 20, hs_pw = 2;
   int vs_per = 2080, vs_pw = 20;
   logic hs_act = 1'b1, vs_act = 1'b1;
   logic hs_on = 1'b0, vs_on = 1'b0;

   sync_meter u_sync_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_vclk  (tick_vclk),
      .win_strobe (win_strobe),
      .hsync_in   (hsync_in),
      .vsync_in   (vsync_in),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .sync_irq   (sync_irq),
      .hsync_out  (hsync_out),
      .vsync_out  (vsync_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin : gen_tick
      int c;
      c = 0;
      forever begin
         @(negedge clk);
         if (tick_per <= 1) tick_vclk = 1'b1;
         else begin
            tick_vclk = (c == 0);
            c = (c + 1 >= tick_per) ? 0 : c + 1;
         end
      end
   end

   initial begin : gen_win
      int c;
      c = 0;
      forever begin
         @(negedge clk);
         win_strobe = (c == 0);
         c = (c + 1 >= win_per) ? 0 : c + 1;
      end
   end

   initial begin : gen_hs
      int ph;
      ph = 0;
      forever begin
         @(negedge clk);
         if (!hs_on) begin hsync_in = ~hs_act; ph = 0; end
         else begin
            hsync_in = (ph < hs_pw) ? hs_act : ~hs_act;
            ph = (ph + 1 >= hs_per) ? 0 : ph + 1;
         end
      end
   end

   initial begin : gen_vs
      int ph;
      ph = 0;
      forever begin
         @(negedge clk);
         if (!vs_on) begin vsync_in = ~vs_act; ph = 0; end
         else begin
            vsync_in = (ph < vs_pw) ? vs_act : ~vs_act;
            ph = (ph + 1 >= vs_per) ? 0 : ph + 1;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic a, output logic [9:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic a, input logic [2:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_bit(input int bitpos, input int limit, output logic [9:0] st);
      for (int i = 0; i < limit; i++) begin
         bus_read(1'b1, st);
         if (st[bitpos]) break;
      end
   endtask

   task automatic count_high(input logic sel_v, input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1 if (sel_v ? vsync_out : hsync_out) hi++;
      end
   endtask

   task automatic restart_vertical();
      logic [9:0] st, d;
      bus_read(1'b1, st);
      if (st[5] == 1'b0) bus_read(1'b0, d);
      bus_read(1'b0, d);
   endtask

   task automatic t_reset();
      logic [9:0] st, d;
      bus_read(1'b1, st);
      chk("R1 status after reset", st, 0);
      bus_read(1'b1, d);
      #1 chk("R1 irq after reset", sync_irq, 0);
      @(negedge clk);
      #1 d = bus_rdata; // addr still 1 here; select count without read strobe
      bus_addr = 1'b0;
      #1 chk("R1 count after reset", bus_rdata, 0);
   endtask

   task automatic t_vertical();
      logic [9:0] st, d;
      bus_write(1'b1, 3'b100);
      wait_bit(0, 3000, st);
      chk("R2 ready set", st[0], 1);
      chk("R2 mode vertical", st[5], 0);
      chk("R8 no overflow", st[2:1], 0);
      #1 chk("R3 irq with enable", sync_irq, 1);
      bus_read(1'b1, st);
      chk("R4 status read keeps ready", st[0], 1);
      chk("R4 status read keeps mode", st[5], 0);
      bus_read(1'b0, d);
      chk("R2 vertical count", d, 520);
      bus_read(1'b1, st);
      chk("R4 ready cleared", st[0], 0);
      chk("R4 mode toggled to horizontal", st[5], 1);
      #1 chk("R3 irq dropped", sync_irq, 0);
   endtask

   task automatic t_horizontal();
      logic [9:0] st, d;
      wait_bit(0, 4000, st);
      chk("R5 ready set", st[0], 1);
      chk("R5 mode horizontal", st[5], 1);
      bus_read(1'b0, d);
      chk("R5 horizontal count", d, 128);
      bus_read(1'b1, st);
      chk("R4 mode back to vertical", st[5], 0);
   endtask

   task automatic t_polarity();
      logic [9:0] st;
      bus_read(1'b1, st);
      chk("R6 hpol positive", st[4], 1);
      chk("R6 vpol positive", st[3], 1);
      hs_act = 1'b0;
      vs_act = 1'b0;
      repeat (3 * 2080) @(negedge clk);
      bus_read(1'b1, st);
      chk("R6 hpol negative", st[4], 0);
      chk("R6 vpol negative", st[3], 0);
   endtask

   task automatic t_regen();
      int hi;
      // inputs are negative now
      bus_write(1'b1, 3'b010);
      count_high(1'b0, 20, hi);
      chk("R7 hsync_out positive from negative input", hi, 2);
      count_high(1'b1, 2080, hi);
      chk("R7 vsync_out negative", hi, 2060);
      bus_write(1'b1, 3'b001);
      count_high(1'b0, 20, hi);
      chk("R7 hsync_out negative", hi, 18);
      count_high(1'b1, 2080, hi);
      chk("R7 vsync_out positive from negative input", hi, 20);
      hs_act = 1'b1;
      repeat (100) @(negedge clk);
      count_high(1'b0, 20, hi);
      chk("R7 hsync_out negative from positive input", hi, 18);
   endtask

   task automatic t_ovf_once();
      logic [9:0] st, d;
      tick_per = 1;
      vs_per   = 1500;
      repeat (2 * 2080) @(negedge clk);
      restart_vertical();
      wait_bit(0, 4000, st);
      chk("R8 ready after single wrap", st[0], 1);
      chk("R8 first overflow set", st[1], 1);
      chk("R8 second overflow clear", st[2], 0);
      bus_read(1'b0, d);
      chk("R8 residue count", d, 476);
   endtask

   task automatic t_ovf_twice();
      logic [9:0] st, d;
      vs_per = 4000;
      repeat (6000) @(negedge clk);
      restart_vertical();
      wait_bit(1, 6000, st);
      chk("R8 first wrap seen", st[1], 1);
      chk("R8 not ready after first wrap", st[0], 0);
      chk("R10 second flag clear", st[2], 0);
      wait_bit(0, 3000, st);
      chk("R9 ready after second wrap", st[0], 1);
      chk("R9 second overflow set", st[2], 1);
      chk("R9 first overflow cleared", st[1], 0);
      bus_write(1'b1, 3'b100);
      #1 chk("R3 irq on double wrap", sync_irq, 1);
      bus_write(1'b1, 3'b000);
      #1 chk("R3 irq masked", sync_irq, 0);
      bus_write(1'b0, 3'b111);
      bus_read(1'b1, st);
      chk("R11 write at count address ignored", st[8:6], 0);
      #1 chk("R11 irq still masked", sync_irq, 0);
      bus_read(1'b0, d);
      chk("R9 count stopped at zero", d, 0);
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      hs_on = 1'b1;
      vs_on = 1'b1;
      t_vertical();
      t_horizontal();
      t_polarity();
      t_regen();
      t_ovf_once();
      t_ovf_twice();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule